// File: doc/BRIEF.md
# Memory Power Domain Sequencer

This block is a hardware state machine that switches a video-processing power domain on or off when asked. A one-cycle pulse on `on_req` or `off_req` starts a fixed sequence. The sequence drives the domain's power switch, the isolation clamp, several banks of memory power-down bits, a bulk reset and a clock enable. It waits a programmed number of microsecond ticks between steps. The memory bits change a few at a time, so the inrush current of the memory macros is spread over many small steps.

On power-up the block does these steps in order:
1. It closes the power switch.
2. It wakes the paired memory banks two bits per step.
3. It wakes the single-bit bank one bit per step.
4. It pulses reset around the removal of isolation.
5. It enables the clocks.

Power-down clamps isolation first and puts the memories to sleep in the same order. It then opens the switch, waits a long settle time and gates the clocks. Power-down never touches reset. A two-bit variant input chooses between two memory bank layouts; any other code is refused with an error pulse. While a sequence runs, `busy` is high and every request is dropped. If `on_req` and `off_req` arrive in the same idle cycle, power-up wins.

Top module: `mem_pwr_seq`

## Requirements
- R1: After reset the outputs are in the off state: `sw_off`=1, `iso_en`=1, all memory power-down bits 1, `dom_rst`=1, `clk_en`=0, `dom_on`=0, `busy`=0, `done`=0 and `err`=0.
- R2: An accepted power-up request clears `sw_off` at the accepting clock edge. The first memory step happens exactly T_SETTLE ticks later.
- R3: Memory steps follow one another every T_STEP ticks.
  - Each step in a paired bank changes bits {2k+1,2k}, for k from 0 upward, so a bank takes BANK_W/2 steps. Bank A comes first, then bank B.
  - The single-bit bank follows, one bit per step from bit 0 upward.
  - A power-up step clears its bits and a power-down step sets them.
- R4: With `variant`=0 (base) the block handles banks A and B, and bank C keeps its value. With `variant`=1 (extended) bank C is handled after bank B and before the single-bit bank. The variant is latched when the request is accepted.
- R5: On power-up, T_STEP ticks after the last memory step a further T_SETTLE ticks elapse; then on consecutive cycles:
  - `dom_rst` is set to 1;
  - `iso_en` is cleared to 0;
  - `dom_rst` is cleared to 0;
  - `clk_en` and `dom_on` are set to 1.
- R6: An accepted power-down request sets `iso_en` at the accepting edge. The first memory step happens T_SETTLE ticks later. Later steps follow the R3 order and spacing, setting bits.
- R7: On power-down, T_STEP+T_SETTLE ticks after the last memory step `sw_off` is set to 1. T_OFF ticks after that, `clk_en` and `dom_on` are cleared. `dom_rst` keeps its value throughout power-down.
- R8: A request while idle with `variant` of 2 or 3 raises `err` for exactly one cycle. It starts nothing and changes no other output.
- R9: `on_req`, `off_req` and `variant` changes that arrive while `busy`=1 have no effect on the running sequence and raise no `err`.
- R10: `busy` is 1 from the accepting edge until the final action. `done` is a one-cycle pulse, with `busy`=0, at the end of each completed sequence.
- R11: Wait counters advance only on cycles where `tick`=1, so a slower tick stretches every wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle microsecond strobe |
| on_req | input | 1 | Power-up request pulse |
| off_req | input | 1 | Power-down request pulse |
| variant | input | 2 | Bank layout: 0 base, 1 extended, 2/3 refused |
| sw_off | output | 1 | Domain power switch control, 1 = switch open |
| iso_en | output | 1 | Isolation clamp, 1 = clamped |
| mem_pd_a | output | BANK_W | Memory power-down bank A |
| mem_pd_b | output | BANK_W | Memory power-down bank B |
| mem_pd_c | output | BANK_W | Memory power-down bank C (extended only) |
| mem_pd_s | output | SOLO_W | Single-bit-step memory power-down bank |
| dom_rst | output | 1 | Bulk domain reset, 1 = held |
| clk_en | output | 1 | Domain clock enable |
| busy | output | 1 | Sequence in progress |
| dom_on | output | 1 | Domain is fully powered |
| done | output | 1 | One-cycle pulse at sequence end |
| err | output | 1 | One-cycle pulse on refused variant |

## Verification
The bench uses the following parameters:
- 8-bit paired banks, giving four steps per bank;
- a 4-bit single-bit bank;
- T_SETTLE=3, T_STEP=2 and T_OFF=6.

With these values a full power-up or power-down takes a few dozen cycles. The bench can therefore compare every output on every cycle against an arithmetic timeline, for both variants and both directions. The small banks also make bank C's hold-versus-sweep behaviour and the step boundaries between banks easy to see. A run with the tick slowed to one in three cycles, together with refused-variant and busy-time requests, covers the remaining requirements.

// File: rtl/mem_pwr_seq.sv
module mem_pwr_seq #(
  parameter int BANK_W   = 32,
  parameter int SOLO_W   = 8,
  parameter int T_SETTLE = 20,
  parameter int T_STEP   = 5,
  parameter int T_OFF    = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              on_req,
  input  logic              off_req,
  input  logic [1:0]        variant,
  output logic              sw_off,
  output logic              iso_en,
  output logic [BANK_W-1:0] mem_pd_a,
  output logic [BANK_W-1:0] mem_pd_b,
  output logic [BANK_W-1:0] mem_pd_c,
  output logic [SOLO_W-1:0] mem_pd_s,
  output logic              dom_rst,
  output logic              clk_en,
  output logic              busy,
  output logic              dom_on,
  output logic              done,
  output logic              err
);
  localparam int PAIRS   = BANK_W / 2;
  localparam int IDX_MAX = (PAIRS > SOLO_W) ? PAIRS : SOLO_W;
  localparam int IDX_W   = (IDX_MAX > 1) ? $clog2(IDX_MAX) : 1;
  localparam int T_BIG   = (T_OFF > T_SETTLE) ? ((T_OFF > T_STEP) ? T_OFF : T_STEP)
                                              : ((T_SETTLE > T_STEP) ? T_SETTLE : T_STEP);
  localparam int CNT_W   = $clog2(T_BIG + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_HEAD, S_MEM, S_TAIL, S_ISO_REL, S_RST_REL, S_CLK_ON, S_OFF
  } state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       bk;
  logic [IDX_W-1:0] idx;
  logic             fin, down, ext;
  logic             ld;
  logic [CNT_W-1:0] ld_val;

  wire start   = (st == S_IDLE) && (on_req || off_req) && (variant < 2'd2);
  wire refuse  = (st == S_IDLE) && (on_req || off_req) && (variant >= 2'd2);
  wire expire  = tick && (cnt == CNT_W'(1));
  wire do_step = expire && ((st == S_HEAD) || (st == S_MEM && !fin));
  wire last    = (bk == 2'd3) ? (int'(idx) == SOLO_W - 1) : (int'(idx) == PAIRS - 1);

  assign busy = (st != S_IDLE);

  always_comb begin
    ld = 1'b0;
    ld_val = '0;
    case (st)
      S_IDLE: if (start)  begin ld = 1'b1; ld_val = CNT_W'(T_SETTLE); end
      S_HEAD: if (expire) begin ld = 1'b1; ld_val = CNT_W'(T_STEP); end
      S_MEM:  if (expire) begin ld = 1'b1; ld_val = fin ? CNT_W'(T_SETTLE) : CNT_W'(T_STEP); end
      S_TAIL: if (expire && down) begin ld = 1'b1; ld_val = CNT_W'(T_OFF); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (ld)                cnt <= ld_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_pd_a <= '1;
      mem_pd_b <= '1;
      mem_pd_c <= '1;
      mem_pd_s <= '1;
      bk  <= '0;
      idx <= '0;
      fin <= 1'b0;
    end else if (start) begin
      bk  <= '0;
      idx <= '0;
      fin <= 1'b0;
    end else if (do_step) begin
      case (bk)
        2'd0:    mem_pd_a[2*int'(idx) +: 2] <= {2{down}};
        2'd1:    mem_pd_b[2*int'(idx) +: 2] <= {2{down}};
        2'd2:    mem_pd_c[2*int'(idx) +: 2] <= {2{down}};
        default: mem_pd_s[int'(idx)]        <= down;
      endcase
      if (last) begin
        idx <= '0;
        case (bk)
          2'd0:    bk <= 2'd1;
          2'd1:    bk <= ext ? 2'd2 : 2'd3;
          2'd2:    bk <= 2'd3;
          default: fin <= 1'b1;
        endcase
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      down    <= 1'b0;
      ext     <= 1'b0;
      sw_off  <= 1'b1;
      iso_en  <= 1'b1;
      dom_rst <= 1'b1;
      clk_en  <= 1'b0;
      dom_on  <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= refuse;
      case (st)
        S_IDLE: if (start) begin
          down <= !on_req;
          ext  <= variant[0];
          if (on_req) sw_off <= 1'b0;
          else        iso_en <= 1'b1;
          st <= S_HEAD;
        end
        S_HEAD: if (expire) st <= S_MEM;
        S_MEM:  if (expire && fin) st <= S_TAIL;
        S_TAIL: if (expire) begin
          if (down) begin
            sw_off <= 1'b1;
            st     <= S_OFF;
          end else begin
            dom_rst <= 1'b1;
            st      <= S_ISO_REL;
          end
        end
        S_ISO_REL: begin iso_en  <= 1'b0; st <= S_RST_REL; end
        S_RST_REL: begin dom_rst <= 1'b0; st <= S_CLK_ON;  end
        S_CLK_ON: begin
          clk_en <= 1'b1;
          dom_on <= 1'b1;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        S_OFF: if (expire) begin
          clk_en <= 1'b0;
          dom_on <= 1'b0;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mem_pwr_seq_chk.sv
module mem_pwr_seq_chk #(
  parameter int BANK_W = 32,
  parameter int SOLO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              on_req,
  input logic              off_req,
  input logic              sw_off,
  input logic              iso_en,
  input logic [BANK_W-1:0] mem_pd_a,
  input logic [BANK_W-1:0] mem_pd_b,
  input logic [BANK_W-1:0] mem_pd_c,
  input logic [SOLO_W-1:0] mem_pd_s,
  input logic              dom_rst,
  input logic              clk_en,
  input logic              busy,
  input logic              done,
  input logic              err
);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_refuse_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(sw_off) && $stable(iso_en) && $stable(clk_en) && $stable(dom_rst) && !busy));
  p_busy_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (on_req || off_req)) |=> !err);
  p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(mem_pd_a) && $stable(mem_pd_b) && $stable(mem_pd_c) && $stable(mem_pd_s)));
  p_iso_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_en |-> (!sw_off && mem_pd_a == '0 && mem_pd_b == '0 && mem_pd_s == '0));
  p_on_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !busy) |-> (!iso_en && !dom_rst && !sw_off));
endmodule

bind mem_pwr_seq mem_pwr_seq_chk #(.BANK_W(BANK_W), .SOLO_W(SOLO_W)) u_chk (.*);

// File: tb/sim_mem_pwr_seq.sv
module sim_mem_pwr_seq;
  localparam int BW = 8, SW = 4, L = 3, S = 2, O = 6, P = BW / 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, on_req = 1'b0, off_req = 1'b0;
  logic [1:0] variant = 2'd0;
  logic sw_off, iso_en, dom_rst, clk_en, busy, dom_on, done, err;
  logic [BW-1:0] mem_pd_a, mem_pd_b, mem_pd_c;
  logic [SW-1:0] mem_pd_s;
  int checks = 0, errors = 0, cyc = 0;
  logic r0 = 1'b1;
  logic [BW-1:0] c0 = '1;

  always #10 clk = ~clk;

  mem_pwr_seq #(.BANK_W(BW), .SOLO_W(SW), .T_SETTLE(L), .T_STEP(S), .T_OFF(O)) u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int e, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s e=%0d act=%h exp=%h", tag, e, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  task automatic run_seq(input bit dn, input bit ext);
    int n  = ext ? 3 * P + SW : 2 * P + SW;
    int t  = L + n * S + L;
    int ed = dn ? t + O + 2 : t + 5;
    @(negedge clk);
    variant = {1'b0, ext};
    if (dn) off_req = 1'b1; else on_req = 1'b1;
    for (int e = 0; e <= ed; e++) begin
      int d, na, nb, nc, ns;
      logic [7:0] ea, eb, ec, es;
      @(negedge clk);
      on_req = 1'b0; off_req = 1'b0; variant = 2'd0;
      d  = (e < L) ? 0 : clampi((e - L) / S + 1, n);
      na = clampi(d, P);
      nb = clampi(d - P, P);
      nc = ext ? clampi(d - 2 * P, P) : 0;
      ns = clampi(d - (ext ? 3 * P : 2 * P), SW);
      ea = 8'((1 << (2 * na)) - 1);
      eb = 8'((1 << (2 * nb)) - 1);
      ec = 8'((1 << (2 * nc)) - 1);
      es = 8'((1 << ns) - 1);
      if (!dn) begin ea = ~ea; eb = ~eb; ec = ~ec; es = 8'(~es & 8'h0F); end
      if (!ext) ec = c0;
      chk("R3 bankA", e, mem_pd_a, ea);
      chk("R3 bankB", e, mem_pd_b, eb);
      chk("R4 bankC", e, mem_pd_c, ec);
      chk("R3 solo", e, 8'(mem_pd_s), es);
      chk("R9 err", e, 8'(err), 8'd0);
      if (!dn) begin
        chk("R2 sw_off", e, 8'(sw_off), 8'd0);
        chk("R5 iso", e, 8'(iso_en), 8'(e < t + 1));
        chk("R5 rst", e, 8'(dom_rst), (e < t) ? 8'(r0) : 8'(e < t + 2));
        chk("R5 clk", e, 8'(clk_en), 8'(e >= t + 3));
        chk("R5 dom_on", e, 8'(dom_on), 8'(e >= t + 3));
        chk("R10 busy", e, 8'(busy), 8'(e < t + 3));
        chk("R10 done", e, 8'(done), 8'(e == t + 3));
      end else begin
        chk("R7 sw_off", e, 8'(sw_off), 8'(e >= t));
        chk("R6 iso", e, 8'(iso_en), 8'd1);
        chk("R7 rst", e, 8'(dom_rst), 8'(r0));
        chk("R7 clk", e, 8'(clk_en), 8'(e < t + O));
        chk("R7 dom_on", e, 8'(dom_on), 8'(e < t + O));
        chk("R10 busy", e, 8'(busy), 8'(e < t + O));
        chk("R10 done", e, 8'(done), 8'(e == t + O));
      end
      // R9: stray requests and a refused code while busy
      if (e == 6) begin off_req = 1'b1; variant = 2'd2; end
      if (e == 9) on_req = 1'b1;
      if (e == 11) begin off_req = 1'b1; on_req = 1'b1; variant = {1'b0, ~ext}; end
    end
    if (!dn) r0 = 1'b0;
    if (ext) c0 = dn ? '1 : '0;
  endtask

  initial begin
    int t0;
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sw_off", 0, 8'(sw_off), 8'd1);
    chk("R1 iso", 0, 8'(iso_en), 8'd1);
    chk("R1 mem", 0, mem_pd_a & mem_pd_b & mem_pd_c, 8'hFF);
    chk("R1 solo", 0, 8'(mem_pd_s), 8'h0F);
    chk("R1 rst", 0, 8'(dom_rst), 8'd1);
    chk("R1 clk/dom/busy/done/err", 0, 8'({clk_en, dom_on, busy, done, err}), 8'd0);

    run_seq(1'b0, 1'b0);
    run_seq(1'b1, 1'b0);
    run_seq(1'b0, 1'b1);
    run_seq(1'b1, 1'b1);

    // R11: tick one cycle in three stretches every wait
    t0 = L + (2 * P + SW) * S + L;
    tick = 1'b0;
    @(negedge clk);
    on_req = 1'b1;
    e = 0;
    @(negedge clk);
    on_req = 1'b0;
    while (!done && e < 1000) begin
      if (e == t0 + 3) chk("R11 busy_slow", e, 8'(busy), 8'd1);
      tick = (e % 3 == 2);
      @(negedge clk);
      e++;
    end
    tick = 1'b1;
    chk("R11 done_late", e, 8'(e >= 3 * t0 - 3 && e <= 3 * t0 + 6), 8'd1);
    chk("R11 dom_on", e, 8'(dom_on), 8'd1);

    // R8: refused variant codes while idle and on
    for (int k = 2; k <= 3; k++) begin
      @(negedge clk);
      variant = 2'(k);
      if (k == 2) on_req = 1'b1; else off_req = 1'b1;
      @(negedge clk);
      on_req = 1'b0; off_req = 1'b0; variant = 2'd0;
      chk("R8 err", k, 8'(err), 8'd1);
      chk("R8 busy", k, 8'(busy), 8'd0);
      chk("R8 outs", k, 8'({sw_off, iso_en, dom_rst, clk_en, dom_on}), 8'b00011);
      chk("R8 mem", k, mem_pd_a | mem_pd_b | 8'(mem_pd_s), 8'h00);
      @(negedge clk);
      chk("R8 err_pulse", k, 8'(err), 8'd0);
      chk("R8 busy_after", k, 8'(busy), 8'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule